// File: doc/BRIEF.md
# Heuristic Global History Reset Unit

This block keeps the speculative global history of taken/not-taken outcomes for a gshare-style direction predictor. It also overwrites that history at control-flow points where later branches tend not to correlate with earlier ones. Three such points are recognised: a call, a return, and a conditional backward branch that goes not-taken, which usually marks a loop exit. At each point the history is replaced with a value derived from the instruction's own PC. Each of the three triggers has its own enable bit, so all eight combinations can be selected. A PC-derived value gives each reset point a distinct history, and every later visit to the same point gets the same history again.

The fetch side presents one instruction per cycle with its kind, PC, direction and predicted outcome. Each conditional branch takes a checkpoint of the old history in a small circular buffer and receives a tag. Branches resolve oldest first. On a misprediction the block restores the branch's checkpoint, applies the corrected outcome (which may itself be a reset) and drops every younger checkpoint. The block includes a table of 2-bit saturating counters indexed by PC XOR history, so that the quality of its predictions can be observed at the ports.

Top module: `ghist_reset_unit`

## Requirements
- R1: After reset the history is all zeros, the checkpoint buffer is empty with the next tag 0, and every counter holds weakly not-taken (binary 01).
- R2: A conditional fetch (kind 0) that does not trigger a reset shifts the history left by one and puts the predicted outcome in bit 0. This covers a forward branch, a backward branch predicted taken, and a backward not-taken branch while its enable is off.
- R3: A conditional backward branch predicted not-taken, with the backward enable set, loads the history with the seed of its PC.
- R4: A call (kind 1) loads the history with the seed of its PC when the call enable is set, and leaves the history unchanged when it is clear. A call never allocates a checkpoint.
- R5: A return (kind 2) behaves like a call under the return enable.
- R6: The seed is PC bits [GHR_W+1:2]. When those bits are all zero, the seed is SEED_ALT (0xA5B by default), so a seed is never zero.
- R7: A resolve flagged as mispredicted restores the branch's checkpoint. The history then becomes the branch's seed if the branch is backward, the corrected outcome is not-taken and the backward enable is set. Otherwise it becomes the checkpoint shifted left with the corrected outcome in bit 0. A fetch in the same cycle is ignored.
- R8: Each conditional branch takes the checkpoint slot at the tag shown on fetch_tag_o, and tags advance by one modulo CKPT_DEPTH (8). Resolves arrive oldest first. A mispredict discards all younger checkpoints, which empties the buffer. ckpt_full_o is high while 8 checkpoints are held, and a conditional fetch in that state changes nothing.
- R9: pred_idx_o is PC bits [IDX_W+1:2] XOR the low IDX_W history bits. pred_taken_o is the most significant bit of the counter at that index.
- R10: Every resolve updates the counter at the index stored with its checkpoint, using res_taken_i: it counts up on taken and down on not-taken, and saturates at 0 and 3.
- R11: Kind 3 changes neither the history nor the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_call_en_i | input | 1 | Enable reset on calls |
| cfg_ret_en_i | input | 1 | Enable reset on returns |
| cfg_bwnt_en_i | input | 1 | Enable reset on not-taken backward branches |
| fetch_valid_i | input | 1 | Fetch slot valid |
| fetch_kind_i | input | 2 | 0 conditional, 1 call, 2 return, 3 other |
| fetch_pc_i | input | PC_W | Instruction PC |
| fetch_backward_i | input | 1 | Branch target lies below the PC |
| fetch_pred_taken_i | input | 1 | Outcome predicted at fetch |
| res_valid_i | input | 1 | Resolve of the oldest outstanding branch |
| res_tag_i | input | TAG_W | Tag of the resolving branch |
| res_mispred_i | input | 1 | Branch was mispredicted |
| res_taken_i | input | 1 | Actual outcome |
| ghr_o | output | GHR_W | Current speculative history |
| pred_idx_o | output | IDX_W | Counter index for the fetch PC |
| pred_taken_o | output | 1 | Counter prediction for the fetch PC |
| fetch_tag_o | output | TAG_W | Tag a conditional fetch would receive |
| ckpt_full_o | output | 1 | All checkpoint slots in use |

## Verification
A wrong history shows up on ghr_o on the clock edge right after the fetch or resolve that caused it. Because pred_idx_o is formed from that history, the same error reaches the index in the same cycle. A corrupted checkpoint stays hidden until that branch resolves as mispredicted. The restored history is then wrong one edge later, so the bench mispredicts branches that sit deep in the buffer, behind younger ones. A miscounted tail or occupancy count shows at once on fetch_tag_o and ckpt_full_o. A counter error shows on pred_taken_o when the same PC and history return in a later fetch.

// File: rtl/ghr_pkg.sv
package ghr_pkg;
  typedef enum logic [1:0] {
    BK_COND = 2'd0,
    BK_CALL = 2'd1,
    BK_RET  = 2'd2,
    BK_NONE = 2'd3
  } br_kind_e;
endpackage

// File: rtl/ghr_seed_gen.sv
module ghr_seed_gen #(
  parameter int unsigned GHR_W    = 12,
  parameter int unsigned SEED_ALT = 32'hA5B
) (
  input  logic [GHR_W-1:0] pc_word_i,
  output logic [GHR_W-1:0] seed_o
);
  localparam logic [GHR_W-1:0] ALT = GHR_W'(SEED_ALT);
  // zero history would alias with the reset state, so substitute
  assign seed_o = (pc_word_i == '0) ? ALT : pc_word_i;
endmodule

// File: rtl/ghr_ckpt_buf.sv
module ghr_ckpt_buf #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned TAG_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [DW-1:0]    push_data_i,
  input  logic             pop_i,
  input  logic             flush_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [TAG_W-1:0] tail_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [TAG_W-1:0] head_q, tail_q;
  logic [TAG_W:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (flush_i) begin
      // everything younger than rd_tag_i is dropped
      head_q <= rd_tag_i + 1'b1;
      tail_q <= rd_tag_i + 1'b1;
      cnt_q  <= '0;
    end else begin
      if (push_i) begin
        mem_q[tail_q] <= push_data_i;
        tail_q        <= tail_q + 1'b1;
      end
      if (pop_i) head_q <= head_q + 1'b1;
      cnt_q <= cnt_q + {{TAG_W{1'b0}}, push_i} - {{TAG_W{1'b0}}, pop_i};
    end
  end

  assign rd_data_o = mem_q[rd_tag_i];
  assign tail_o    = tail_q;
  assign full_o    = (cnt_q == (TAG_W+1)'(DEPTH));
  assign empty_o   = (cnt_q == '0);
endmodule

// File: rtl/ghr_ctr_table.sv
module ghr_ctr_table #(
  parameter int unsigned IDX_W = 10,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_taken_o,
  input  logic             upd_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_taken_i
);
  logic [1:0] ctr_q [ENTRIES];
  logic [1:0] cur, nxt;

  assign cur = ctr_q[upd_idx_i];

  always_comb begin
    nxt = cur;
    if (upd_taken_i && cur != 2'b11)       nxt = cur + 2'b01;
    else if (!upd_taken_i && cur != 2'b00) nxt = cur - 2'b01;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= 2'b01;
    end else if (upd_i) begin
      ctr_q[upd_idx_i] <= nxt;
    end
  end

  assign rd_taken_o = ctr_q[rd_idx_i][1];
endmodule

// File: rtl/ghist_reset_unit.sv
module ghist_reset_unit
  import ghr_pkg::*;
#(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned GHR_W      = 12,
  parameter int unsigned IDX_W      = 10,
  parameter int unsigned CKPT_DEPTH = 8,
  parameter int unsigned SEED_ALT   = 32'hA5B,
  localparam int unsigned TAG_W     = $clog2(CKPT_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_call_en_i,
  input  logic             cfg_ret_en_i,
  input  logic             cfg_bwnt_en_i,
  input  logic             fetch_valid_i,
  input  logic [1:0]       fetch_kind_i,
  input  logic [PC_W-1:0]  fetch_pc_i,
  input  logic             fetch_backward_i,
  input  logic             fetch_pred_taken_i,
  input  logic             res_valid_i,
  input  logic [TAG_W-1:0] res_tag_i,
  input  logic             res_mispred_i,
  input  logic             res_taken_i,
  output logic [GHR_W-1:0] ghr_o,
  output logic [IDX_W-1:0] pred_idx_o,
  output logic             pred_taken_o,
  output logic [TAG_W-1:0] fetch_tag_o,
  output logic             ckpt_full_o
);
  localparam int unsigned HI = ((GHR_W > IDX_W) ? GHR_W : IDX_W) + 2;
  localparam int unsigned DW = 1 + 2 * GHR_W + IDX_W;

  br_kind_e         kind;
  logic [GHR_W-1:0] ghr_q, ghr_d, seed_f;
  logic [IDX_W-1:0] fetch_idx;
  logic             full, empty, res_fire, res_mis, push;
  logic [DW-1:0]    push_data, rd_data;
  logic             r_bw;
  logic [GHR_W-1:0] r_seed, r_ghr;
  logic [IDX_W-1:0] r_idx;
  logic             unused_bits;

  assign kind        = br_kind_e'(fetch_kind_i);
  assign unused_bits = ^{fetch_pc_i[PC_W-1:HI], fetch_pc_i[1:0], r_ghr[GHR_W-1]};

  ghr_seed_gen #(.GHR_W(GHR_W), .SEED_ALT(SEED_ALT)) u_seed (
    .pc_word_i (fetch_pc_i[GHR_W+1:2]),
    .seed_o    (seed_f)
  );

  assign fetch_idx = fetch_pc_i[IDX_W+1:2] ^ ghr_q[IDX_W-1:0];
  assign res_fire  = res_valid_i && !empty;
  assign res_mis   = res_fire && res_mispred_i;
  assign push      = fetch_valid_i && kind == BK_COND && !full && !res_mis;
  assign push_data = {fetch_backward_i, seed_f, ghr_q, fetch_idx};
  assign {r_bw, r_seed, r_ghr, r_idx} = rd_data;

  ghr_ckpt_buf #(.DEPTH(CKPT_DEPTH), .DW(DW)) u_ckpt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (res_fire),
    .flush_i     (res_mis),
    .rd_tag_i    (res_tag_i),
    .rd_data_o   (rd_data),
    .tail_o      (fetch_tag_o),
    .full_o      (full),
    .empty_o     (empty)
  );

  ghr_ctr_table #(.IDX_W(IDX_W)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (fetch_idx),
    .rd_taken_o  (pred_taken_o),
    .upd_i       (res_fire),
    .upd_idx_i   (r_idx),
    .upd_taken_i (res_taken_i)
  );

  always_comb begin
    ghr_d = ghr_q;
    if (res_mis) begin
      if (r_bw && !res_taken_i && cfg_bwnt_en_i) ghr_d = r_seed;
      else                                       ghr_d = {r_ghr[GHR_W-2:0], res_taken_i};
    end else if (fetch_valid_i) begin
      unique case (kind)
        BK_COND: if (!full) begin
          if (fetch_backward_i && !fetch_pred_taken_i && cfg_bwnt_en_i) ghr_d = seed_f;
          else ghr_d = {ghr_q[GHR_W-2:0], fetch_pred_taken_i};
        end
        BK_CALL: if (cfg_call_en_i) ghr_d = seed_f;
        BK_RET:  if (cfg_ret_en_i)  ghr_d = seed_f;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ghr_q <= '0;
    else         ghr_q <= ghr_d;
  end

  assign ghr_o       = ghr_q;
  assign pred_idx_o  = fetch_idx;
  assign ckpt_full_o = full;
endmodule

// File: rtl/ghist_reset_unit_chk.sv
module ghist_reset_unit_chk #(
  parameter int unsigned GHR_W      = 12,
  parameter int unsigned CKPT_DEPTH = 8,
  localparam int unsigned TAG_W     = $clog2(CKPT_DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_call_en_i,
  input logic             cfg_ret_en_i,
  input logic             fetch_valid_i,
  input logic [1:0]       fetch_kind_i,
  input logic             fetch_backward_i,
  input logic             fetch_pred_taken_i,
  input logic             res_valid_i,
  input logic             res_mispred_i,
  input logic [GHR_W-1:0] ghr_o,
  input logic [TAG_W-1:0] fetch_tag_o,
  input logic             ckpt_full_o
);
  logic [GHR_W-1:0] ghr_sh;
  logic [TAG_W-1:0] tag_nx;
  logic             cond_f;
  assign ghr_sh = {ghr_o[GHR_W-2:0], fetch_pred_taken_i};
  assign tag_nx = fetch_tag_o + 1'b1;
  assign cond_f = fetch_valid_i && fetch_kind_i == 2'd0 && !res_valid_i;

  a_r2_forward_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_f && !fetch_backward_i && !ckpt_full_o) |=> ghr_o == $past(ghr_sh));
  a_r4_call_off_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && fetch_kind_i == 2'd1 && !cfg_call_en_i && !res_valid_i) |=> $stable(ghr_o));
  a_r5_ret_off_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && fetch_kind_i == 2'd2 && !cfg_ret_en_i && !res_valid_i) |=> $stable(ghr_o));
  a_r6_seed_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && fetch_kind_i == 2'd1 && cfg_call_en_i && !res_valid_i) |=> ghr_o != '0);
  a_r8_tag_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_f && !ckpt_full_o) |=> fetch_tag_o == $past(tag_nx));
  a_r8_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_f && ckpt_full_o) |=> $stable(ghr_o) && ckpt_full_o);
  a_r8_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_mispred_i) |=> !ckpt_full_o);
endmodule

bind ghist_reset_unit ghist_reset_unit_chk #(.GHR_W(GHR_W), .CKPT_DEPTH(CKPT_DEPTH)) u_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .cfg_call_en_i      (cfg_call_en_i),
  .cfg_ret_en_i       (cfg_ret_en_i),
  .fetch_valid_i      (fetch_valid_i),
  .fetch_kind_i       (fetch_kind_i),
  .fetch_backward_i   (fetch_backward_i),
  .fetch_pred_taken_i (fetch_pred_taken_i),
  .res_valid_i        (res_valid_i),
  .res_mispred_i      (res_mispred_i),
  .ghr_o              (ghr_o),
  .fetch_tag_o        (fetch_tag_o),
  .ckpt_full_o        (ckpt_full_o)
);

// File: tb/ghist_reset_unit_tb.sv
`timescale 1ns/1ps
module ghist_reset_unit_tb;
  logic        clk = 0, rst_n = 0;
  logic        call_en = 1, ret_en = 1, bwnt_en = 1;
  logic        f_valid = 0, f_bw = 0, f_pred = 0;
  logic [1:0]  f_kind = 2'd3;
  logic [31:0] f_pc = '0;
  logic        r_valid = 0, r_mis = 0, r_taken = 0;
  logic [2:0]  r_tag = '0;
  logic [11:0] ghr;
  logic [9:0]  pidx;
  logic        ptaken, full;
  logic [2:0]  ftag;

  int n_chk = 0, n_bad = 0;
  logic [11:0] ghr_m = '0;
  logic [11:0] m_old [8];
  logic [11:0] m_seed [8];
  logic        m_bw [8];
  logic [9:0]  m_idx [8];
  logic [1:0]  ctr_m [1024];
  logic [2:0]  head_m = '0, tail_m = '0;
  int          cnt_m = 0;

  always #2.5 clk = ~clk;

  ghist_reset_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_call_en_i(call_en), .cfg_ret_en_i(ret_en), .cfg_bwnt_en_i(bwnt_en),
    .fetch_valid_i(f_valid), .fetch_kind_i(f_kind), .fetch_pc_i(f_pc),
    .fetch_backward_i(f_bw), .fetch_pred_taken_i(f_pred),
    .res_valid_i(r_valid), .res_tag_i(r_tag), .res_mispred_i(r_mis), .res_taken_i(r_taken),
    .ghr_o(ghr), .pred_idx_o(pidx), .pred_taken_o(ptaken),
    .fetch_tag_o(ftag), .ckpt_full_o(full)
  );

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  function automatic logic [11:0] seed_f(input logic [31:0] pc);
    return (pc[13:2] == 12'h000) ? 12'hA5B : pc[13:2];
  endfunction

  task automatic chk_ghr(input string what);
    chk(ghr == ghr_m, what, {20'h0, ghr}, {20'h0, ghr_m});
  endtask

  task automatic do_fetch(input logic [1:0] k, input logic [31:0] pc, input logic bw, input logic pred);
    logic [9:0] idx;
    f_valid = 1; f_kind = k; f_pc = pc; f_bw = bw; f_pred = pred;
    #1;
    idx = pc[11:2] ^ ghr_m[9:0];
    chk(pidx == idx, "R9 index", {22'h0, pidx}, {22'h0, idx});
    chk(ptaken == ctr_m[idx][1], "R9 counter msb", {31'h0, ptaken}, {31'h0, ctr_m[idx][1]});
    if (k == 2'd0 && cnt_m < 8) begin
      chk(ftag == tail_m, "R8 tag", {29'h0, ftag}, {29'h0, tail_m});
      m_old[tail_m] = ghr_m; m_seed[tail_m] = seed_f(pc); m_bw[tail_m] = bw; m_idx[tail_m] = idx;
      tail_m = tail_m + 1; cnt_m++;
      if (bw && !pred && bwnt_en) ghr_m = seed_f(pc);
      else                        ghr_m = {ghr_m[10:0], pred};
    end else if (k == 2'd1 && call_en) ghr_m = seed_f(pc);
    else if (k == 2'd2 && ret_en)      ghr_m = seed_f(pc);
    @(posedge clk); #1;
    f_valid = 0; f_kind = 2'd3;
  endtask

  task automatic model_resolve(input logic mis, input logic taken);
    logic [1:0] c;
    if (cnt_m == 0) return;
    c = ctr_m[m_idx[head_m]];
    if (taken && c != 2'b11) c = c + 1;
    else if (!taken && c != 2'b00) c = c - 1;
    ctr_m[m_idx[head_m]] = c;
    if (mis) begin
      if (m_bw[head_m] && !taken && bwnt_en) ghr_m = m_seed[head_m];
      else ghr_m = {m_old[head_m][10:0], taken};
      head_m = head_m + 1; tail_m = head_m; cnt_m = 0;
    end else begin
      head_m = head_m + 1; cnt_m--;
    end
  endtask

  task automatic do_resolve(input logic mis, input logic taken);
    r_valid = 1; r_tag = head_m; r_mis = mis; r_taken = taken;
    model_resolve(mis, taken);
    @(posedge clk); #1;
    r_valid = 0; r_mis = 0;
  endtask

  task automatic drain();
    while (cnt_m > 0) do_resolve(1'b0, 1'b0);
    chk(!full, "R8 drained not full", {31'h0, full}, 0);
  endtask

  task automatic t_reset();
    chk(ghr == 12'h000, "R1 history zero", {20'h0, ghr}, 0);
    chk(!full && ftag == 3'd0, "R1 buffer empty", {28'h0, full, ftag}, 0);
    f_pc = 32'h0000_0abc; #1;
    chk(ptaken == 1'b0, "R1 weak not-taken", {31'h0, ptaken}, 0);
  endtask

  task automatic t_shift();
    do_fetch(2'd0, 32'h100, 0, 1); chk(ghr == 12'h001, "R2 shift taken", {20'h0, ghr}, 32'h001);
    do_fetch(2'd0, 32'h104, 0, 0); chk(ghr == 12'h002, "R2 shift not-taken", {20'h0, ghr}, 32'h002);
    do_fetch(2'd0, 32'h108, 1, 1); chk(ghr == 12'h005, "R2 backward taken shifts", {20'h0, ghr}, 32'h005);
    do_fetch(2'd3, 32'h10c, 1, 0); chk(ghr == 12'h005, "R11 kind 3 ignored", {20'h0, ghr}, 32'h005);
    chk(ftag == tail_m, "R11 no checkpoint", {29'h0, ftag}, {29'h0, tail_m});
    drain();
  endtask

  task automatic t_bwnt();
    do_fetch(2'd0, 32'h1234, 1, 0); chk(ghr == 12'h48D, "R3 backward not-taken reset", {20'h0, ghr}, 32'h48D);
    bwnt_en = 0;
    do_fetch(2'd0, 32'h1234, 1, 0); chk(ghr == 12'h91A, "R2 backward reset disabled", {20'h0, ghr}, 32'h91A);
    bwnt_en = 1;
    do_fetch(2'd0, 32'h1230, 0, 0); chk_ghr("R2 forward not-taken no reset");
    drain();
  endtask

  task automatic t_call_ret();
    logic [2:0] t0;
    t0 = ftag;
    do_fetch(2'd1, 32'h2000, 0, 0); chk(ghr == 12'h800, "R4 call seed", {20'h0, ghr}, 32'h800);
    do_fetch(2'd2, 32'h3008, 0, 0); chk(ghr == 12'hC02, "R5 return seed", {20'h0, ghr}, 32'hC02);
    chk(ftag == t0, "R4 call no checkpoint", {29'h0, ftag}, {29'h0, t0});
    call_en = 0; ret_en = 0;
    do_fetch(2'd1, 32'h4444, 0, 0); chk(ghr == 12'hC02, "R4 call disabled", {20'h0, ghr}, 32'hC02);
    do_fetch(2'd2, 32'h5550, 0, 0); chk(ghr == 12'hC02, "R5 return disabled", {20'h0, ghr}, 32'hC02);
    call_en = 1; ret_en = 1;
  endtask

  task automatic t_zero_seed();
    do_fetch(2'd1, 32'h0000_4000, 0, 0); chk(ghr == 12'hA5B, "R6 zero seed substitute", {20'h0, ghr}, 32'hA5B);
    do_fetch(2'd1, 32'h0000_1000, 0, 0); chk(ghr == 12'h400, "R6 seed bits", {20'h0, ghr}, 32'h400);
    do_fetch(2'd2, 32'hFFFF_C000, 0, 0); chk(ghr == 12'hA5B, "R6 zero seed on return", {20'h0, ghr}, 32'hA5B);
  endtask

  task automatic t_mispred();
    do_fetch(2'd1, 32'h2000, 0, 0);
    do_fetch(2'd0, 32'h1234, 1, 0);
    do_resolve(1, 1); chk(ghr == 12'h001, "R7 restore and shift taken", {20'h0, ghr}, 32'h001);
    do_fetch(2'd0, 32'h1234, 1, 1); chk(ghr == 12'h003, "R2 predicted taken shifts", {20'h0, ghr}, 32'h003);
    do_resolve(1, 0); chk(ghr == 12'h48D, "R7 late reset on not-taken", {20'h0, ghr}, 32'h48D);
    bwnt_en = 0;
    do_fetch(2'd0, 32'h1234, 1, 1);
    do_resolve(1, 0); chk(ghr == 12'h91A, "R7 restore shift when disabled", {20'h0, ghr}, 32'h91A);
    bwnt_en = 1;
    // mispredict wins over a same-cycle fetch
    do_fetch(2'd0, 32'h0200, 0, 1);
    f_valid = 1; f_kind = 2'd1; f_pc = 32'h7000; r_valid = 1; r_tag = head_m; r_mis = 1; r_taken = 0;
    model_resolve(1, 0);
    @(posedge clk); #1;
    f_valid = 0; f_kind = 2'd3; r_valid = 0; r_mis = 0;
    chk(ghr == 12'h234, "R7 same-cycle fetch ignored", {20'h0, ghr}, 32'h234);
  endtask

  task automatic t_flush();
    do_fetch(2'd1, 32'h2000, 0, 0);
    do_fetch(2'd0, 32'h100, 0, 1);
    do_fetch(2'd0, 32'h104, 0, 1);
    do_fetch(2'd0, 32'h108, 0, 1);
    chk(ghr == 12'h007, "R2 three shifts", {20'h0, ghr}, 32'h007);
    do_resolve(1, 0); chk(ghr == 12'h000, "R7 oldest checkpoint restored", {20'h0, ghr}, 0);
    chk(ftag == head_m, "R8 younger discarded", {29'h0, ftag}, {29'h0, head_m});
  endtask

  task automatic t_full();
    for (int i = 0; i < 8; i++) do_fetch(2'd0, 32'h300 + i * 4, 0, 0);
    chk(full, "R8 full after 8", {31'h0, full}, 1);
    do_fetch(2'd0, 32'h400, 0, 1); chk_ghr("R8 fetch while full ignored");
    chk(full, "R8 still full", {31'h0, full}, 1);
    drain();
  endtask

  task automatic t_counters();
    logic [1:0] seq [5] = '{2'd1, 2'd1, 2'd1, 2'd0, 2'd0};
    logic [4:0] exp_p = 5'b01111; // msb before each resolve: 01,10,11,11,10 -> then 01
    for (int i = 0; i < 5; i++) begin
      do_fetch(2'd1, 32'h2000, 0, 0);
      do_fetch(2'd0, 32'h40, 0, 0);
      chk(ctr_m[10'h010][1] == exp_p[4-i], "R10 saturating sequence", {31'h0, ctr_m[10'h010][1]}, {31'h0, exp_p[4-i]});
      do_resolve(1'b0, seq[i][0]);
    end
    do_fetch(2'd1, 32'h2000, 0, 0);
    f_pc = 32'h40; #1;
    chk(ptaken == 1'b0, "R10 back to weak not-taken", {31'h0, ptaken}, 0);
    chk(pidx == 10'h010, "R9 index value", {22'h0, pidx}, 32'h010);
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) ctr_m[i] = 2'b01;
    #12 rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_shift();
    t_bwnt();
    t_call_ret();
    t_zero_seed();
    t_mispred();
    t_flush();
    t_full();
    t_counters();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule